// File: doc/BRIEF.md
# Parallel Video Capture with Resolution Detection

This block sits at the input of a video path. It takes a 16-bit 4:2:2 luma/chroma parallel bus in the pixel clock domain, together with a separate vertical sync line and a data-enable line. The samples arrive interleaved as Cb, Y, Cr, Y. The block forwards each sample downstream through a single register stage. It marks every new frame with a one-cycle start-of-frame pulse.

Alongside the pass-through, the block measures the active picture. The width is the number of data-enable cycles in a line. The height is the number of lines that end between two vsync rising edges. Both values are latched once per frame, at the same edge that raises the start-of-frame pulse. The first values latched after the source locks describe a partial frame. From the second frame on, the values match the source timing, for example 1920x1080 or 1280x720.

Horizontal sync is not needed, because data enable alone marks the extent of each line.

Top module: `vcap_top`

## Requirements
- R1: `pix_o` equals `vid_i` from the previous clock cycle. The sample order Cb/Y/Cr/Y passes through unchanged.
- R2: `pix_vld_o` equals `de_i` from the previous clock cycle.
- R3: `sof_o` is high for exactly one cycle, in the cycle after a sampled low-to-high transition of `vs_i` (active high).
- R4: If `vs_i` is already high when reset is released, no `sof_o` pulse is produced until `vs_i` has gone low and then high again.
- R5: At a start-of-frame, `act_w_o` takes the number of consecutive `de_i`-high cycles in the last line that ended before or at that vsync edge.
- R6: At a start-of-frame, `act_h_o` takes the number of `de_i` falling edges seen since the previous vsync rising edge.
- R7: `act_w_o` and `act_h_o` change only in the cycle in which `sof_o` is high. They hold their values for the rest of the frame.
- R8: After reset, the first start-of-frame latches only what was seen before it, which is 0x0 when no line has ended yet. The second start-of-frame reports the full frame dimensions.
- R9: While `rst` is high, all outputs are zero one cycle after the first reset edge.
- R10: The width and height counts saturate at 4095 and do not wrap.
- R11: A data-enable falling edge in the same cycle as a vsync rising edge counts toward the frame that is closing. That line's width is the one latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_i | input | 16 | 4:2:2 pixel sample |
| vs_i | input | 1 | Vertical sync, active high |
| de_i | input | 1 | Data enable |
| pix_o | output | 16 | Pixel sample delayed one cycle |
| pix_vld_o | output | 1 | Data enable delayed one cycle |
| sof_o | output | 1 | One-cycle start-of-frame pulse |
| act_w_o | output | 12 | Active pixels per line |
| act_h_o | output | 12 | Active lines per frame |

## Verification
Faults in the pixel counter or the last-line capture register are hidden until the next vsync edge. They then appear as a wrong `act_w_o`, so their latency is one frame. A line counter that fails to clear, or that double counts, shows up as a wrong `act_h_o` at the following start-of-frame. Edge-detector faults are visible at once: `sof_o` goes missing, doubles, or fires spuriously in the cycle after the bad sample. The bench sweeps many small width and height combinations so that each of these faults shows within one or two frames.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
    localparam int PIX_W_DEF = 16;
    localparam int DIM_W_DEF = 12;

    typedef struct packed {
        logic vs_rise;
        logic de_rise;
        logic de_fall;
    } vcap_edges_t;
endpackage

// File: rtl/vcap_edge.sv
module vcap_edge
    import vcap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        vs_i,
    input  logic        de_i,
    output vcap_edges_t edg_o,
    output logic        sof_o
);
    logic vs_q;
    logic de_q;
    logic primed;

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_q   <= 1'b0;
            de_q   <= 1'b0;
            primed <= 1'b0;
            sof_o  <= 1'b0;
        end else begin
            vs_q   <= vs_i;
            de_q   <= de_i;
            primed <= 1'b1;
            sof_o  <= edg_o.vs_rise;
        end
    end

    always_comb begin
        edg_o.vs_rise = primed &  vs_i & ~vs_q;
        edg_o.de_rise = primed &  de_i & ~de_q;
        edg_o.de_fall = primed & ~de_i &  de_q;
    end

    // R3
    sof_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sof_o |=> !sof_o);
    // R3
    sof_src_chk: assert property (@(posedge clk) disable iff (rst)
        sof_o |-> $past(vs_i));
    // R4
    sof_prime_chk: assert property (@(posedge clk) disable iff (rst)
        !primed |=> !sof_o);
endmodule

// File: rtl/vcap_pipe.sv
module vcap_pipe #(
    parameter int PIX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] data_i,
    input  logic             de_i,
    output logic [PIX_W-1:0] pix_o,
    output logic             vld_o
);
    logic chk_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_o  <= '0;
            vld_o  <= 1'b0;
            chk_ok <= 1'b0;
        end else begin
            pix_o  <= data_i;
            vld_o  <= de_i;
            chk_ok <= 1'b1;
        end
    end

    // R1
    pix_dly_chk: assert property (@(posedge clk) disable iff (rst)
        chk_ok |-> pix_o == $past(data_i));
    // R2
    vld_dly_chk: assert property (@(posedge clk) disable iff (rst)
        chk_ok |-> vld_o == $past(de_i));
endmodule

// File: rtl/vcap_meas.sv
module vcap_meas
    import vcap_pkg::*;
#(
    parameter int DIM_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             de_i,
    input  vcap_edges_t      edg_i,
    output logic [DIM_W-1:0] width_o,
    output logic [DIM_W-1:0] height_o
);
    localparam logic [DIM_W-1:0] CNT_MAX = {DIM_W{1'b1}};

    logic [DIM_W-1:0] pix_cnt;
    logic [DIM_W-1:0] line_w;
    logic [DIM_W-1:0] line_cnt;
    logic [DIM_W-1:0] line_w_nxt;
    logic [DIM_W-1:0] line_cnt_nxt;

    always_comb begin
        line_w_nxt   = edg_i.de_fall ? pix_cnt : line_w;
        line_cnt_nxt = (edg_i.de_fall && line_cnt != CNT_MAX) ? line_cnt + 1'b1 : line_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_cnt <= '0;
        end else if (edg_i.de_rise) begin
            pix_cnt <= {{(DIM_W-1){1'b0}}, 1'b1};
        end else if (de_i && pix_cnt != CNT_MAX) begin
            pix_cnt <= pix_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_w   <= '0;
            line_cnt <= '0;
            width_o  <= '0;
            height_o <= '0;
        end else begin
            line_w <= line_w_nxt;
            if (edg_i.vs_rise) begin
                width_o  <= line_w_nxt;
                height_o <= line_cnt_nxt;
                line_cnt <= '0;
            end else begin
                line_cnt <= line_cnt_nxt;
            end
        end
    end

    // R7
    dims_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !edg_i.vs_rise |=> $stable(width_o) && $stable(height_o));
    // R6
    line_clr_chk: assert property (@(posedge clk) disable iff (rst)
        edg_i.vs_rise |=> line_cnt == '0);
    // R10
    pix_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_cnt == CNT_MAX && de_i && !edg_i.de_rise) |=> pix_cnt == CNT_MAX);
    // R10
    line_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (line_cnt == CNT_MAX && !edg_i.vs_rise) |=> line_cnt == CNT_MAX);
endmodule

// File: rtl/vcap_top.sv
module vcap_top
    import vcap_pkg::*;
#(
    parameter int PIX_W = PIX_W_DEF,
    parameter int DIM_W = DIM_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] vid_i,
    input  logic             vs_i,
    input  logic             de_i,
    output logic [PIX_W-1:0] pix_o,
    output logic             pix_vld_o,
    output logic             sof_o,
    output logic [DIM_W-1:0] act_w_o,
    output logic [DIM_W-1:0] act_h_o
);
    vcap_edges_t edg;

    vcap_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .vs_i  (vs_i),
        .de_i  (de_i),
        .edg_o (edg),
        .sof_o (sof_o)
    );

    vcap_pipe #(.PIX_W(PIX_W)) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .data_i (vid_i),
        .de_i   (de_i),
        .pix_o  (pix_o),
        .vld_o  (pix_vld_o)
    );

    vcap_meas #(.DIM_W(DIM_W)) u_meas (
        .clk      (clk),
        .rst      (rst),
        .de_i     (de_i),
        .edg_i    (edg),
        .width_o  (act_w_o),
        .height_o (act_h_o)
    );

    // R7
    sof_dims_chk: assert property (@(posedge clk) disable iff (rst)
        (act_w_o != $past(act_w_o) || act_h_o != $past(act_h_o)) |-> sof_o);
endmodule

// File: tb/sim_vcap_top.sv
module sim_vcap_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] vid_i = '0;
    logic        vs_i = 1'b0;
    logic        de_i = 1'b0;
    logic [15:0] pix_o;
    logic        pix_vld_o;
    logic        sof_o;
    logic [11:0] act_w_o;
    logic [11:0] act_h_o;

    int n_chk = 0;
    int n_err = 0;
    int seq   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    // reference model of the requirements, fed from the bench's own stimulus
    int m_run, m_lastw, m_lines, m_w, m_h;
    bit prev_de, prev_vs, primed;
    int sof_seen;

    always #10 clk = ~clk;

    vcap_top u0 (
        .clk(clk), .rst(rst), .vid_i(vid_i), .vs_i(vs_i), .de_i(de_i),
        .pix_o(pix_o), .pix_vld_o(pix_vld_o), .sof_o(sof_o),
        .act_w_o(act_w_o), .act_h_o(act_h_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > 4095) ? 4095 : v;
    endfunction

    task automatic tick(input bit v, input bit e);
        logic [15:0] d;
        bit de_r, de_f, vs_r, exp_sof;
        int lw;
        d = {seq[7:0], ~seq[7:0]} ^ 16'h3c00;
        seq++;
        @(negedge clk);
        vid_i = d; vs_i = v; de_i = e;
        de_r = primed && e && !prev_de;
        de_f = primed && !e && prev_de;
        vs_r = primed && v && !prev_vs;
        exp_sof = 1'b0;
        if (rst) begin
            m_run = 0; m_lastw = 0; m_lines = 0; m_w = 0; m_h = 0;
        end else begin
            lw = de_f ? m_run : m_lastw;
            if (vs_r) begin
                m_w = lw;
                m_h = sat(m_lines + (de_f ? 1 : 0));
                m_lines = 0;
            end else if (de_f) begin
                m_lines = sat(m_lines + 1);
            end
            m_lastw = lw;
            if (de_r) m_run = 1;
            else if (e) m_run = sat(m_run + 1);
            exp_sof = vs_r;
        end
        @(posedge clk);
        #1;
        if (rst) begin
            chk(pix_o == 16'h0 && !pix_vld_o && !sof_o && act_w_o == 0 && act_h_o == 0,
                "R9 reset clears outputs", int'(pix_o), 0);
        end else begin
            chk(pix_o == d, "R1 pixel delay", int'(pix_o), int'(d));
            chk(pix_vld_o == e, "R2 valid delay", int'(pix_vld_o), int'(e));
            chk(sof_o == exp_sof, "R3 frame pulse", int'(sof_o), int'(exp_sof));
            chk(int'(act_w_o) == m_w, "R7 width held/updated", int'(act_w_o), m_w);
            chk(int'(act_h_o) == m_h, "R7 height held/updated", int'(act_h_o), m_h);
            if (sof_o) sof_seen++;
        end
        prev_de = rst ? 1'b0 : e;
        prev_vs = rst ? 1'b0 : v;
        primed  = !rst;
    endtask

    task automatic do_reset(input bit v);
        rst = 1'b1;
        for (int i = 0; i < 3; i++) tick(v, 1'b0);
        rst = 1'b0;
    endtask

    // lines of the frame; the vsync rising edge that closes it is the last tick
    task automatic frame_body(input int w, input int h, input bit coincide);
        for (int l = 0; l < h; l++) begin
            for (int p = 0; p < w; p++) tick(1'b0, 1'b1);
            if (coincide && l == h - 1) begin
                tick(1'b1, 1'b0);
            end else begin
                for (int b = 0; b < 3; b++) tick(1'b0, 1'b0);
            end
        end
        if (!coincide) tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    initial begin
        // R9 and R8: reset, then the first vsync with no lines seen latches 0x0
        do_reset(1'b0);
        tick(1'b0, 1'b0);
        tick(1'b1, 1'b0);
        chk(sof_o == 1'b1, "R3 first pulse", int'(sof_o), 1);
        chk(act_w_o == 0 && act_h_o == 0, "R8 first frame dims", int'(act_w_o), 0);
        tick(1'b1, 1'b0);
        chk(sof_o == 1'b0, "R3 single cycle", int'(sof_o), 0);
        tick(1'b0, 1'b0);

        // R5/R6: sweep width and height; the second frame reports the full size
        for (int w = 1; w <= 6; w++) begin
            for (int h = 1; h <= 4; h++) begin
                frame_body(w, h, 1'b0);
                chk(int'(act_w_o) == w, "R5 width after frame", int'(act_w_o), w);
                chk(int'(act_h_o) == h, "R6 height after frame", int'(act_h_o), h);
            end
        end

        // R11: last line ends in the same cycle as the vsync edge
        for (int w = 2; w <= 4; w++) begin
            frame_body(w, 3, 1'b1);
            chk(int'(act_w_o) == w, "R11 coincident width", int'(act_w_o), w);
            chk(int'(act_h_o) == 3, "R11 coincident height", int'(act_h_o), 3);
        end

        // R8: mid-frame reset; first frame partial, second frame exact
        frame_body(3, 2, 1'b0);
        do_reset(1'b0);
        for (int p = 0; p < 2; p++) tick(1'b0, 1'b0);
        for (int p = 0; p < 5; p++) tick(1'b0, 1'b1);
        tick(1'b0, 1'b0);
        tick(1'b1, 1'b0);
        chk(int'(act_w_o) == 5 && int'(act_h_o) == 1, "R8 partial frame", int'(act_w_o), 5);
        tick(1'b0, 1'b0);
        frame_body(7, 5, 1'b0);
        chk(int'(act_w_o) == 7 && int'(act_h_o) == 5, "R8 second frame", int'(act_h_o), 5);

        // R4: vsync high across reset release gives no pulse until it toggles
        sof_seen = 0;
        do_reset(1'b1);
        for (int p = 0; p < 6; p++) tick(1'b1, 1'b0);
        chk(sof_seen == 0, "R4 no pulse while vsync held", sof_seen, 0);
        tick(1'b0, 1'b0);
        tick(1'b1, 1'b0);
        chk(sof_seen == 1, "R4 pulse after toggle", sof_seen, 1);
        tick(1'b0, 1'b0);

        // R10: width and height saturate at 4095
        frame_body(4100, 1, 1'b0);
        chk(int'(act_w_o) == 4095, "R10 width saturates", int'(act_w_o), 4095);
        for (int l = 0; l < 4100; l++) begin
            tick(1'b0, 1'b1);
            tick(1'b0, 1'b0);
        end
        tick(1'b1, 1'b0);
        chk(int'(act_h_o) == 4095, "R10 height saturates", int'(act_h_o), 4095);
        tick(1'b0, 1'b0);

        done = 1'b1;
    end

    always @(posedge clk) cyc++;

    initial begin
        wait (done || cyc > 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule